// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a general-purpose I/O port of up to sixteen pins behind a 32-bit register interface. Software picks a per-pin pad mode (input, push-pull, open-drain or quasi-bidirectional) and writes an output data latch. It reads back the synchronized pin levels. It also arms interrupt detection on each pin.

Detection is chosen per pin. It can be edge sensitive or level sensitive, and it has one enable for the low or falling polarity and another for the high or rising polarity. Detected events are held in a pending register. Software clears that register by writing ones, and a single interrupt line is raised while any pending bit is set.

The register port is a plain valid/write/address strobe. A write is taken on any clock edge where valid and write are both high. Read data follows the address combinationally.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is all 0 and `irq` is 0.
- R2: A pin whose 2-bit mode field (bits [2n+1:2n] of offset 0x00) holds 0 is an input, and its `pad_oe` bit is 0.
- R3: Mode 1 is push-pull. `pad_oe` is 1 and `pad_out` equals the output data bit (offset 0x08, bit n).
- R4: Mode 2 is open-drain. With data 0 the pin drives low (`pad_oe`=1, `pad_out`=0). With data 1 the pin is released (`pad_oe`=0).
- R5: Mode 3 is quasi-bidirectional. It drives high for exactly one cycle after the data bit changes from 0 to 1, and otherwise behaves as open-drain.
- R6: Offset 0x10 returns the pin levels in bits [15:0], two clock edges after the pad changes. Writes to this offset have no effect.
- R7: When type bit n (offset 0x18) is 0, detection is by edge. Enable bit n (offset 0x1C) arms a falling edge, enable bit n+16 arms a rising edge, and both together arm both edges. An edge of a polarity that is not enabled sets nothing.
- R8: When type bit n is 1, detection is by level. The pending bit is set on every cycle the enabled level is present, so a clear does not hold while that level persists.
- R9: Writing 1 to bit n of offset 0x20 clears pending bit n, and writing 0 leaves it unchanged. A pending bit is set on the third clock edge after its pad edge.
- R10: When a clear and a new detection hit the same pending bit in the same cycle, the bit ends up set.
- R11: `irq` is high exactly when at least one pending bit is set.
- R12: Offsets 0x00, 0x08, 0x18 and 0x1C read back the value written. Unmapped offsets such as 0x04 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default of sixteen pins. At that width the mode register fills all 32 bits, and the rising and high-level enables run up to bit 31. This puts the split enable layout and the full-width mode fields within reach of both the directed cases and the random mode and data patterns. Directed sequences place a clear write on the same edge as a fresh edge detection. They also hold a level through a clear and probe each single-polarity enable with the opposite edge.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  localparam int HI = 16;
  localparam logic [5:0] A_MODE = 6'h00;
  localparam logic [5:0] A_DATA = 6'h08;
  localparam logic [5:0] A_PIN  = 6'h10;
  localparam logic [5:0] A_TYPE = 6'h18;
  localparam logic [5:0] A_IEN  = 6'h1C;
  localparam logic [5:0] A_SRC  = 6'h20;

  logic [2*NPINS-1:0] mode_q;
  logic [NPINS-1:0] dout_q, dprev_q, type_q, ien_lo, ien_hi, src_q;
  logic [NPINS-1:0] sync1_q, sync2_q, last_q;
  logic [NPINS-1:0] rise, fall, det, clr, pulse;
  logic wr;

  assign wr    = bus_valid && bus_write;
  assign rise  = sync2_q & ~last_q;
  assign fall  = ~sync2_q & last_q;
  assign det   = (type_q & ((ien_hi & sync2_q) | (ien_lo & ~sync2_q)))
               | (~type_q & ((ien_hi & rise) | (ien_lo & fall)));
  assign clr   = (wr && bus_addr == A_SRC) ? bus_wdata[NPINS-1:0] : '0;
  assign pulse = dout_q & ~dprev_q;
  assign irq   = |src_q;
  assign pad_out = pad_oe & dout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dout_q  <= '0;
      dprev_q <= '0;
      type_q  <= '0;
      ien_lo  <= '0;
      ien_hi  <= '0;
      src_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      last_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
      dprev_q <= dout_q;
      src_q   <= (src_q & ~clr) | det;
      if (wr && bus_addr == A_MODE) mode_q <= bus_wdata[2*NPINS-1:0];
      if (wr && bus_addr == A_DATA) dout_q <= bus_wdata[NPINS-1:0];
      if (wr && bus_addr == A_TYPE) type_q <= bus_wdata[NPINS-1:0];
      if (wr && bus_addr == A_IEN) begin
        ien_lo <= bus_wdata[NPINS-1:0];
        ien_hi <= bus_wdata[HI+NPINS-1:HI];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      case (mode_q[2*i +: 2])
        2'd0:    pad_oe[i] = 1'b0;
        2'd1:    pad_oe[i] = 1'b1;
        2'd2:    pad_oe[i] = ~dout_q[i];
        default: pad_oe[i] = ~dout_q[i] | pulse[i];
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE: bus_rdata[2*NPINS-1:0] = mode_q;
      A_DATA: bus_rdata[NPINS-1:0]   = dout_q;
      A_PIN:  bus_rdata[NPINS-1:0]   = sync2_q;
      A_TYPE: bus_rdata[NPINS-1:0]   = type_q;
      A_IEN: begin
        bus_rdata[NPINS-1:0]       = ien_lo;
        bus_rdata[HI+NPINS-1:HI]   = ien_hi;
      end
      A_SRC:  bus_rdata[NPINS-1:0]   = src_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [5:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [2*NPINS-1:0] mode_q,
  input logic [NPINS-1:0] dout_q,
  input logic [NPINS-1:0] ien_lo,
  input logic [NPINS-1:0] ien_hi,
  input logic [NPINS-1:0] src_q,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe
);
  // R2
  input_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd0) |-> !pad_oe[0]);

  // R3
  push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd1) |-> (pad_oe[0] && pad_out[0] == dout_q[0]));

  // R4
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'd2) |-> ((pad_oe[1] == !dout_q[1]) && !pad_out[1]));

  // R5
  quasi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd3 && dout_q[0] && $past(dout_q[0])) |-> !pad_oe[0]);

  // R7
  no_enable_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ien_lo) == '0 && $past(ien_hi) == '0) |-> ((src_q & ~$past(src_q)) == '0));

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 6'h20 && (&bus_wdata[NPINS-1:0])
     && ien_lo == '0 && ien_hi == '0) |=> (src_q == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mode_q(mode_q), .dout_q(dout_q),
  .ien_lo(ien_lo), .ien_hi(ien_hi), .src_q(src_q), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  function automatic logic [NP-1:0] exp_oe(input logic [31:0] m, input logic [NP-1:0] d);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++)
      r[i] = (m[2*i +: 2] == 2'd0) ? 1'b0 : (m[2*i +: 2] == 2'd1) ? 1'b1 : ~d[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] m, d;
    void'($urandom(32'd1234));
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1 reset state
    rd_chk("R1 mode", 6'h00, 0);
    rd_chk("R1 data", 6'h08, 0);
    rd_chk("R1 type", 6'h18, 0);
    rd_chk("R1 ien", 6'h1C, 0);
    rd_chk("R1 src", 6'h20, 0);
    chk("R1 oe", pad_oe, 0);
    chk("R1 irq", irq, 0);

    // R12 readback and unmapped
    wr(6'h00, 32'h1B);
    rd_chk("R12 mode", 6'h00, 32'h1B);
    wr(6'h10, 32'hFFFF);
    rd_chk("R6 pin write ignored", 6'h10, 0);
    rd_chk("R12 unmapped", 6'h04, 0);

    // R2 R3 R4 R5: pin0 quasi, pin1 open-drain, pin2 push-pull, pin3 input
    chk("R4 R5 oe data0", pad_oe, 16'h0007);
    chk("R3 out data0", pad_out, 0);
    wr(6'h08, 32'hF);
    rd_chk("R12 data", 6'h08, 32'hF);
    chk("R5 quasi pulse oe", pad_oe, 16'h0005);
    chk("R5 quasi pulse out", pad_out, 16'h0005);
    wait_n(1);
    chk("R5 quasi release", pad_oe, 16'h0004);
    chk("R2 R3 out", pad_out, 16'h0004);
    wr(6'h08, 32'h0);
    wr(6'h00, 32'h0);

    // R6 two-edge latency
    pad_in = 16'hA5A5;
    wait_n(1);
    rd_chk("R6 one edge", 6'h10, 0);
    wait_n(1);
    rd_chk("R6 two edges", 6'h10, 32'hA5A5);
    pad_in = 0;
    wait_n(3);

    // R7 edge detection: pin4 rise, pin5 fall, pin6 both, pin9 rise
    wr(6'h1C, (32'h1 << 20) | (32'h1 << 5) | (32'h1 << 6) | (32'h1 << 22) | (32'h1 << 25));
    rd_chk("R12 ien", 6'h1C, (32'h1 << 20) | (32'h1 << 5) | (32'h1 << 6) | (32'h1 << 22) | (32'h1 << 25));
    pad_in[4] = 1; wait_n(3);
    rd_chk("R7 rise", 6'h20, 32'h10);
    chk("R11 irq set", irq, 1);
    wr(6'h20, 32'h0);
    rd_chk("R9 write zero", 6'h20, 32'h10);
    wr(6'h20, 32'h10);
    rd_chk("R9 clear", 6'h20, 0);
    chk("R11 irq clear", irq, 0);
    pad_in[4] = 0; wait_n(3);
    rd_chk("R7 fall ignored", 6'h20, 0);
    pad_in[5] = 1; wait_n(3);
    rd_chk("R7 rise ignored", 6'h20, 0);
    pad_in[5] = 0; wait_n(3);
    rd_chk("R7 fall", 6'h20, 32'h20);
    wr(6'h20, 32'h20);
    pad_in[6] = 1; wait_n(3);
    rd_chk("R7 both rise", 6'h20, 32'h40);
    wr(6'h20, 32'h40);
    pad_in[6] = 0; wait_n(3);
    rd_chk("R7 both fall", 6'h20, 32'h40);
    wr(6'h20, 32'h40);

    // R10 clear in detection cycle
    pad_in[9] = 1; wait_n(3);
    rd_chk("R10 first", 6'h20, 32'h200);
    pad_in[9] = 0; wait_n(3);
    rd_chk("R10 fall no change", 6'h20, 32'h200);
    pad_in[9] = 1; wait_n(2);
    wr(6'h20, 32'h200);
    rd_chk("R10 detect wins", 6'h20, 32'h200);
    wr(6'h20, 32'h200);
    rd_chk("R10 then clear", 6'h20, 0);

    // R8 level detection: pin7 high level, pin8 low level
    wr(6'h18, 32'h180);
    rd_chk("R12 type", 6'h18, 32'h180);
    wr(6'h1C, (32'h1 << 23) | (32'h1 << 8));
    wait_n(1);
    rd_chk("R8 low level", 6'h20, 32'h100);
    pad_in[7] = 1; wait_n(3);
    rd_chk("R8 high level", 6'h20, 32'h180);
    wr(6'h20, 32'h180);
    rd_chk("R8 clear not held", 6'h20, 32'h180);
    pad_in[7] = 0;
    wr(6'h1C, 32'h1 << 23);
    wait_n(3);
    wr(6'h20, 32'h180);
    wait_n(1);
    rd_chk("R8 level gone", 6'h20, 0);
    chk("R11 irq low", irq, 0);
    wr(6'h1C, 32'h0);

    // random mode/data patterns
    for (int k = 0; k < 24; k++) begin
      m = $urandom;
      d = $urandom & 32'hFFFF;
      wr(6'h00, m);
      wr(6'h08, d);
      wait_n(1);
      chk("R2 R3 R4 R5 random oe", pad_oe, exp_oe(m, d[NP-1:0]));
      chk("R3 R4 random out", pad_out, exp_oe(m, d[NP-1:0]) & d[NP-1:0]);
      rd_chk("R12 random mode", 6'h00, m);
      pad_in = $urandom;
      wait_n(2);
      rd_chk("R6 random pins", 6'h10, pad_in);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule